// File: doc/BRIEF.md
# Coherent Transaction Broadcast Filter

This block sits between a processor cluster's request source and its coherent interconnect port. For each incoming request it decides whether to send the request out on the interconnect or to resolve it locally. The decision depends on four static configuration inputs and on the request's type and shareability attribute. The four inputs are a barrier-local mode, inner-domain broadcast, outer-domain broadcast and forced maintenance broadcast.

When barriers are resolved locally, the block keeps a count of forwarded reads still waiting for data and forwarded writes still waiting for a response. It accepts a barrier and holds it until both counts drain to zero. While the barrier is held, all younger requests are stalled. Every accepted request receives exactly one acknowledge, which says whether the request was forwarded or kept local. A combinational flag reports an illegal pair of broadcast settings.

Top module: `coh_bcast_filter`

## Requirements
- R1: Request kind is encoded on `req_kind` as 0 barrier, 1 DVM, 2 coherent read, 3 coherent write, 4 cache maintenance. With `cfg_bar_local` low, a barrier is forwarded with `out_kind`=0, and `out_sync` equals `req_sync` (0 memory barrier, 1 synchronization barrier).
- R2: With `cfg_bar_local` high, a barrier is never forwarded. The barrier is accepted, and `ack_valid` with `ack_local`=1 appears one cycle after the first cycle in which both outstanding counts are zero. Until that acknowledge, `req_ready` and `out_valid` stay low.
- R3: A DVM request is forwarded only when `cfg_inner` is high; otherwise it is kept local.
- R4: Shareability on `req_shar` is encoded as 0 non-shareable, 1 inner, 2 outer, 3 treated as non-shareable. A coherent read or write is forwarded only in two cases: inner with `cfg_inner` high, or outer with `cfg_outer` high. Non-shareable reads and writes are always kept local.
- R5: With `cfg_cmo_all` high, every maintenance request is forwarded, including non-shareable ones and those whose domain broadcast is off.
- R6: With `cfg_cmo_all` low, a maintenance request follows the domain rule of R4.
- R7: `config_error` is high exactly when `cfg_inner` is high and `cfg_outer` is low. The setting with barrier-local high and all three broadcast inputs low is legal.
- R8: Forwarded reads and forwarded writes are counted separately, each up to 15. A forwarded read or write is stalled while its own count is 15, and proceeds after a completion.
- R9: A completion pulse (`rd_done` or `wr_done`) arriving while its count is zero sets `cnt_err`. The flag then stays set until reset.
- R10: Each accepted request other than a held barrier yields one `ack_valid` pulse in the cycle after acceptance. `ack_local` is 1 exactly when the request was not forwarded. Acknowledges come back in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_bar_local | input | 1 | Resolve barriers locally instead of sending them |
| cfg_inner | input | 1 | Broadcast inner-shareable traffic and DVM |
| cfg_outer | input | 1 | Broadcast outer-shareable traffic |
| cfg_cmo_all | input | 1 | Forward every cache maintenance request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_kind | input | 3 | Request type |
| req_shar | input | 2 | Shareability attribute |
| req_sync | input | 1 | Barrier flavour |
| out_valid | output | 1 | Forwarded request present |
| out_ready | input | 1 | Interconnect takes the request |
| out_kind | output | 3 | Forwarded type |
| out_shar | output | 2 | Forwarded shareability |
| out_sync | output | 1 | Forwarded barrier flavour |
| rd_done | input | 1 | One forwarded read returned data |
| wr_done | input | 1 | One forwarded write got its response |
| ack_valid | output | 1 | Acknowledge pulse |
| ack_local | output | 1 | Acknowledged request stayed local |
| config_error | output | 1 | Illegal broadcast setting |
| cnt_err | output | 1 | Sticky completion underflow |

## Verification
The hardest case to reach from the ports is a locally held barrier that retires on the exact cycle its last outstanding completion drains. A further younger request must be waiting behind it at the same time. The stimulus first issues one forwarded read and one forwarded write. It then presents the barrier and starts a younger DVM request in the background. It returns the read completion and then the write completion, and samples `ack_valid` on the cycle right after the final drain (expected low) and on the cycle after that (expected high). The counter limit is reached by issuing fifteen forwarded reads while a sixteenth waits. A completion with nothing outstanding then exposes the sticky underflow flag.

// File: rtl/coh_bcast_filter.sv
module coh_bcast_filter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_bar_local,
  input  logic             cfg_inner,
  input  logic             cfg_outer,
  input  logic             cfg_cmo_all,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_kind,
  input  logic [1:0]       req_shar,
  input  logic             req_sync,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2:0]       out_kind,
  output logic [1:0]       out_shar,
  output logic             out_sync,
  input  logic             rd_done,
  input  logic             wr_done,
  output logic             ack_valid,
  output logic             ack_local,
  output logic             config_error,
  output logic             cnt_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [2:0] K_BAR = 3'd0, K_DVM = 3'd1, K_RD = 3'd2, K_WR = 3'd3, K_CMO = 3'd4;

  logic             dom_en, fwd, hold_bar, is_rd, is_wr, full, acc, retire, pending;
  logic             rd_inc, wr_inc, rd_dec, wr_dec;
  logic [CNT_W-1:0] rd_cnt, wr_cnt;

  assign dom_en = (req_shar == 2'd1 && cfg_inner) || (req_shar == 2'd2 && cfg_outer);

  always_comb begin
    case (req_kind)
      K_BAR:      fwd = !cfg_bar_local;
      K_DVM:      fwd = cfg_inner;
      K_RD, K_WR: fwd = dom_en;
      K_CMO:      fwd = cfg_cmo_all || dom_en;
      default:    fwd = 1'b0;
    endcase
  end

  assign hold_bar = req_kind == K_BAR && cfg_bar_local;
  assign is_rd    = req_kind == K_RD;
  assign is_wr    = req_kind == K_WR;
  assign full     = fwd && ((is_rd && rd_cnt == CNT_MAX) || (is_wr && wr_cnt == CNT_MAX));

  assign req_ready = !pending && (!fwd || (out_ready && !full));
  assign out_valid = req_valid && !pending && fwd && !full;
  assign out_kind  = req_kind;
  assign out_shar  = req_shar;
  assign out_sync  = req_sync;

  assign acc    = req_valid && req_ready;
  assign retire = pending && rd_cnt == '0 && wr_cnt == '0;
  assign rd_inc = acc && fwd && is_rd;
  assign wr_inc = acc && fwd && is_wr;
  assign rd_dec = rd_done && rd_cnt != '0;
  assign wr_dec = wr_done && wr_cnt != '0;

  assign config_error = cfg_inner && !cfg_outer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt    <= '0;
      wr_cnt    <= '0;
      pending   <= 1'b0;
      ack_valid <= 1'b0;
      ack_local <= 1'b0;
      cnt_err   <= 1'b0;
    end else begin
      rd_cnt    <= rd_cnt + CNT_W'(rd_inc) - CNT_W'(rd_dec);
      wr_cnt    <= wr_cnt + CNT_W'(wr_inc) - CNT_W'(wr_dec);
      pending   <= (pending && !retire) || (acc && hold_bar);
      ack_valid <= (acc && !hold_bar) || retire;
      ack_local <= retire || (acc && !fwd);
      cnt_err   <= cnt_err || (rd_done && rd_cnt == '0) || (wr_done && wr_cnt == '0);
    end
  end
endmodule

// File: rtl/coh_bcast_filter_chk.sv
module coh_bcast_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_bar_local,
  input logic       cfg_inner,
  input logic       cfg_outer,
  input logic       cfg_cmo_all,
  input logic       out_valid,
  input logic [2:0] out_kind,
  input logic [1:0] out_shar,
  input logic       cnt_err
);
  assert_bar_not_sent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 3'd0) |-> !cfg_bar_local);

  assert_dvm_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 3'd1) |-> cfg_inner);

  assert_rdwr_domain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_kind == 3'd2 || out_kind == 3'd3)) |->
      ((out_shar == 2'd1 && cfg_inner) || (out_shar == 2'd2 && cfg_outer)));

  assert_cmo_domain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 3'd4 && !cfg_cmo_all) |->
      ((out_shar == 2'd1 && cfg_inner) || (out_shar == 2'd2 && cfg_outer)));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_err |=> cnt_err);
endmodule

bind coh_bcast_filter coh_bcast_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_bar_local(cfg_bar_local), .cfg_inner(cfg_inner),
  .cfg_outer(cfg_outer), .cfg_cmo_all(cfg_cmo_all), .out_valid(out_valid),
  .out_kind(out_kind), .out_shar(out_shar), .cnt_err(cnt_err)
);

// File: tb/coh_bcast_filter_bench.sv
module coh_bcast_filter_bench;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_bar_local = 0, cfg_inner = 0, cfg_outer = 0, cfg_cmo_all = 0;
  logic req_valid = 0, req_sync = 0, out_ready = 1, rd_done = 0, wr_done = 0;
  logic [2:0] req_kind = 0;
  logic [1:0] req_shar = 0;
  logic req_ready, out_valid, out_sync, ack_valid, ack_local, config_error, cnt_err;
  logic [2:0] out_kind;
  logic [1:0] out_shar;

  int n_cmp = 0, n_bad = 0;
  logic [5:0] fwd_q[$];
  string      fwd_tag[$];
  logic       ack_q[$];
  string      ack_tag[$];

  coh_bcast_filter u_coh_bcast_filter (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic bit exp_fwd(input logic [2:0] k, input logic [1:0] s);
    bit dom;
    dom = (s == 2'd1 && cfg_inner) || (s == 2'd2 && cfg_outer);
    case (k)
      3'd0: return !cfg_bar_local;
      3'd1: return cfg_inner;
      3'd2, 3'd3: return dom;
      3'd4: return cfg_cmo_all || dom;
      default: return 0;
    endcase
  endfunction

  task automatic send(input logic [2:0] k, input logic [1:0] s, input logic y, input string tag);
    bit f;
    f = exp_fwd(k, s);
    ack_q.push_back(!f);
    ack_tag.push_back(tag);
    if (f) begin
      fwd_q.push_back({k, s, y});
      fwd_tag.push_back(tag);
    end
    @(negedge clk);
    req_valid = 1; req_kind = k; req_shar = s; req_sync = y;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid = 0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_done = 1;
    @(negedge clk); rd_done = 0;
  endtask

  task automatic pulse_wr();
    @(negedge clk); wr_done = 1;
    @(negedge clk); wr_done = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (rst_n) begin
        if (out_valid && out_ready) begin
          if (fwd_q.size() == 0)
            chk(0, "R4 unexpected forward", int'({out_kind, out_shar, out_sync}), -1);
          else begin
            logic [5:0] e;
            string t;
            e = fwd_q.pop_front();
            t = fwd_tag.pop_front();
            chk({out_kind, out_shar, out_sync} == e, t, int'({out_kind, out_shar, out_sync}), int'(e));
          end
        end
        if (ack_valid) begin
          if (ack_q.size() == 0)
            chk(0, "R10 unexpected ack", int'(ack_local), -1);
          else begin
            logic e;
            string t;
            e = ack_q.pop_front();
            t = ack_tag.pop_front();
            chk(ack_local == e, {t, " R10 ack_local"}, int'(ack_local), int'(e));
          end
        end
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    chk(0, "R10 watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ack_valid == 0 && out_valid == 0 && cnt_err == 0, "R10 reset state",
        int'({ack_valid, out_valid, cnt_err}), 0);
    rst_n = 1;

    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cfg_inner = i[0]; cfg_outer = i[1];
      #1;
      chk(config_error == (i == 1), "R7 config_error", int'(config_error), int'(i == 1));
    end
    @(negedge clk);
    cfg_bar_local = 1; cfg_inner = 0; cfg_outer = 0; cfg_cmo_all = 0;
    #1;
    chk(config_error == 0, "R7 legacy setting legal", int'(config_error), 0);

    cfg_bar_local = 0; cfg_inner = 1; cfg_outer = 1;
    send(3'd0, 2'd0, 1'b0, "R1 memory barrier");
    send(3'd0, 2'd0, 1'b1, "R1 sync barrier");

    send(3'd1, 2'd0, 1'b0, "R3 dvm inner on");
    cfg_inner = 0;
    send(3'd1, 2'd0, 1'b0, "R3 dvm inner off");

    cfg_inner = 1;
    send(3'd2, 2'd1, 1'b0, "R4 read inner");
    send(3'd3, 2'd2, 1'b0, "R4 write outer");
    send(3'd2, 2'd0, 1'b0, "R4 read nonshared");
    cfg_inner = 0;
    send(3'd2, 2'd1, 1'b0, "R4 read inner outer-only");
    send(3'd3, 2'd2, 1'b0, "R4 write outer outer-only");
    cfg_outer = 0;
    send(3'd2, 2'd2, 1'b0, "R4 read both off");
    send(3'd3, 2'd1, 1'b0, "R4 write both off");

    cfg_cmo_all = 1;
    send(3'd4, 2'd0, 1'b0, "R5 cmo nonshared forced");
    send(3'd4, 2'd1, 1'b0, "R5 cmo inner forced");
    cfg_cmo_all = 0; cfg_outer = 1;
    send(3'd4, 2'd1, 1'b0, "R6 cmo inner outer-only");
    send(3'd4, 2'd2, 1'b0, "R6 cmo outer outer-only");
    send(3'd4, 2'd0, 1'b0, "R6 cmo nonshared");

    pulse_rd();
    pulse_wr();
    pulse_wr();

    cfg_inner = 1; cfg_outer = 1; cfg_bar_local = 1;
    send(3'd2, 2'd2, 1'b0, "R2 read before barrier");
    send(3'd3, 2'd2, 1'b0, "R2 write before barrier");
    send(3'd0, 2'd0, 1'b0, "R2 held barrier");
    fork
      send(3'd1, 2'd0, 1'b0, "R2 younger dvm");
    join_none
    @(negedge clk); #(CLK_P/4);
    chk(req_ready == 0 && out_valid == 0, "R2 younger stalled", int'({req_ready, out_valid}), 0);
    pulse_rd();
    #(CLK_P/4);
    chk(ack_valid == 0, "R2 no ack with write pending", int'(ack_valid), 0);
    pulse_wr();
    #(CLK_P/4);
    chk(ack_valid == 0, "R2 ack not before counts settle", int'(ack_valid), 0);
    @(negedge clk); #(CLK_P/4);
    chk(ack_valid == 1 && ack_local == 1, "R2 barrier ack timing", int'({ack_valid, ack_local}), 3);
    repeat (4) @(negedge clk);

    cfg_bar_local = 0;
    for (int i = 0; i < 15; i++) send(3'd2, 2'd2, 1'b0, "R8 fill reads");
    fork
      send(3'd2, 2'd2, 1'b0, "R8 read after full");
    join_none
    @(negedge clk); #(CLK_P/4);
    chk(req_ready == 0 && out_valid == 0, "R8 stall at count 15", int'({req_ready, out_valid}), 0);
    pulse_rd();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 15; i++) pulse_rd();

    #(CLK_P/4);
    chk(cnt_err == 0, "R9 no error before underflow", int'(cnt_err), 0);
    pulse_rd();
    #(CLK_P/4);
    chk(cnt_err == 1, "R9 underflow flagged", int'(cnt_err), 1);
    repeat (3) @(negedge clk);
    chk(cnt_err == 1, "R9 error sticky", int'(cnt_err), 1);

    repeat (5) @(negedge clk);
    chk(ack_q.size() == 0, "R10 all acks seen", ack_q.size(), 0);
    chk(fwd_q.size() == 0, "R10 all forwards seen", fwd_q.size(), 0);
    finish_up();
  end
endmodule